// File: doc/BRIEF.md
# Keyslot Configuration Register Bank

This block holds the configuration of a fixed number of encryption keyslots for an inline storage cipher. Each slot owns one 128-byte entry in a register window: sixteen 32-bit key words, a control word carrying the slot's enable flag, its capability index and its data-unit-size mask, an extra 32-bit parameter word and reserved space. Software fills an entry through a simple 32-bit write port and reads the readable words back through a registered read port. The window starts at a configurable pointer multiplied by 0x100.

The bank presents every slot's enable flag, parameters and full 512-bit key to the data path, which picks a slot per request. The bank enforces an enable-last protocol. A slot turns on only when its control word is written with the enable bit set. Any later key write to that slot turns it off again, so the data path never sees an enabled slot whose key is half-written. Key words cannot be read back. Clearing a slot means writing zero to every word of its entry.

Top module: `keyslot_cfg_bank`

## Requirements
- R1: After a synchronous active-low reset every slot is disabled and every stored key, parameter and field is zero.
- R2: Word d (0 to 31) of slot s sits at byte address CFG_PTR*256 + s*128 + d*4. There are NUM_SLOTS slots, and address bits [1:0] are ignored.
- R3: A slot becomes enabled only by a write to its word 16 with bit 31 set. That write also loads the data-unit-size mask from bits [7:0] and the capability index from bits [15:8]. A word-16 write with bit 31 clear loads the fields and disables the slot.
- R4: A write to key word 0 to 15 of an enabled slot stores the key word and clears that slot's enable in the same cycle.
- R5: Key word d of slot s drives bits [s*512 + d*32 +: 32] of the key output. Word 17 is stored whole and output as the slot's extra parameter. All slot outputs change on the clock edge that takes the write.
- R6: Writes below the window base, or to a slot number at or above NUM_SLOTS, change nothing. Reads there return zero.
- R7: Read data is registered and appears one cycle after the read address. Key words and reserved words 18 to 31 read zero, and writes to reserved words are ignored. Word 16 reads {enable, 15'b0, capability index, size mask}, and word 17 reads its stored value.
- R8: A write to one slot leaves every other slot's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte address, sampled every cycle |
| rd_data | output | 32 | Registered read data |
| slot_en | output | NUM_SLOTS | Per-slot enable |
| slot_dus | output | NUM_SLOTS*8 | Per-slot data-unit-size masks |
| slot_cap | output | NUM_SLOTS*8 | Per-slot capability indices |
| slot_ext | output | NUM_SLOTS*32 | Per-slot extra parameter word |
| slot_key | output | NUM_SLOTS*512 | Per-slot 512-bit keys |

## Verification
A write changes the slot outputs on the edge that takes it. The bench drives each write for one cycle from a falling edge and samples the outputs at the next falling edge. A read result appears one edge after its address is presented, so the bench sets the read address at a falling edge and takes rd_data one full cycle later. The bench sweeps every slot and every key word of a four-slot bank. It also covers the boundary cases: a key rewrite of an armed slot, a control write with the enable bit clear, addresses outside the window, low address bits and a full eviction. Expected values are computed from the slot and word numbers.

// File: rtl/keyslot_cfg_pkg.sv
// Shared constants and helpers for the keyslot configuration bank.
// Assumes 128-byte entries addressed as 32 dwords.
package keyslot_cfg_pkg;
    localparam int KEY_DWORDS  = 16;
    localparam int KEY_BITS    = KEY_DWORDS * 32;
    localparam int ENTRY_SHIFT = 7;               // 128 bytes per entry
    localparam logic [4:0] DW_CTRL = 5'd16;
    localparam logic [4:0] DW_EXT  = 5'd17;
    localparam int CTRL_EN_BIT = 31;

    // Builds the readable image of a control word.
    function automatic logic [31:0] ctrl_image(input logic en,
                                               input logic [7:0] cap,
                                               input logic [7:0] dus);
        return {en, 15'b0, cap, dus};
    endfunction
endpackage

// File: rtl/keyslot_addr_dec.sv
// Address decoder: splits a byte address into slot number and dword index
// and flags whether it falls inside the populated part of the window.
// Assumes ADDR_W is large enough to hold the window base plus all entries.
module keyslot_addr_dec #(
    parameter int NUM_SLOTS = 4,
    parameter int CFG_PTR   = 1,
    parameter int ADDR_W    = 12,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [4:0]        dw_o
);
    import keyslot_cfg_pkg::*;

    localparam int BASE = CFG_PTR * 256;
    localparam int SF_W = ADDR_W - ENTRY_SHIFT;

    logic [ADDR_W-1:0] off;
    logic [SF_W-1:0]   slot_field;
    logic              unused_low;

    // Offset from the window base and field extraction.
    always_comb begin
        off        = addr_i - ADDR_W'(BASE);
        slot_field = off[ADDR_W-1:ENTRY_SHIFT];
        hit_o      = (addr_i >= ADDR_W'(BASE)) && (slot_field < SF_W'(NUM_SLOTS));
        slot_o     = slot_field[SLOT_W-1:0];
        dw_o       = off[6:2];
    end

    assign unused_low = ^off[1:0];
endmodule

// File: rtl/keyslot_entry.sv
// One keyslot entry: key storage, control fields and the extra word.
// Enforces enable-last: only a control write can set enable, and any
// key write clears it. Reserved dwords are not stored.
module keyslot_entry (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [4:0]   dw_i,
    input  logic [31:0]  wdata_i,
    output logic         en_o,
    output logic [7:0]   dus_o,
    output logic [7:0]   cap_o,
    output logic [31:0]  ext_o,
    output logic [keyslot_cfg_pkg::KEY_BITS-1:0] key_o
);
    import keyslot_cfg_pkg::*;

    logic [31:0] key_q [KEY_DWORDS];
    logic        unused_rsvd;

    // Entry state update on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o  <= 1'b0;
            dus_o <= '0;
            cap_o <= '0;
            ext_o <= '0;
            for (int i = 0; i < KEY_DWORDS; i++) key_q[i] <= '0;
        end else if (we_i) begin
            if (dw_i < 5'(KEY_DWORDS)) begin
                key_q[dw_i[3:0]] <= wdata_i;
                en_o             <= 1'b0;
            end else if (dw_i == DW_CTRL) begin
                en_o  <= wdata_i[CTRL_EN_BIT];
                cap_o <= wdata_i[15:8];
                dus_o <= wdata_i[7:0];
            end else if (dw_i == DW_EXT) begin
                ext_o <= wdata_i;
            end
        end
    end

    // Flatten key words onto the data-path bus.
    for (genvar g = 0; g < KEY_DWORDS; g++) begin : g_key
        assign key_o[g*32 +: 32] = key_q[g];
    end

    assign unused_rsvd = ^wdata_i[30:16];

    // R4: a key write always leaves the slot disabled
    a_r4_key_write_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && dw_i < 5'd16) |=> !en_o);

    // R3: enable rises only after a control write with the enable bit set
    a_r3_enable_by_ctrl_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_o) |-> $past(we_i && dw_i == 5'd16 && wdata_i[31]));
endmodule

// File: rtl/keyslot_cfg_bank.sv
// Top of the keyslot configuration bank: decodes write and read
// addresses, holds NUM_SLOTS entries and serves registered read-back.
// Assumes one write and one read address per cycle; a read in the
// same cycle as a write to the same word returns the old value.
module keyslot_cfg_bank #(
    parameter int NUM_SLOTS = 4,
    parameter int CFG_PTR   = 1,
    parameter int ADDR_W    = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [31:0]               wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [31:0]               rd_data,
    output logic [NUM_SLOTS-1:0]      slot_en,
    output logic [NUM_SLOTS*8-1:0]    slot_dus,
    output logic [NUM_SLOTS*8-1:0]    slot_cap,
    output logic [NUM_SLOTS*32-1:0]   slot_ext,
    output logic [NUM_SLOTS*512-1:0]  slot_key
);
    import keyslot_cfg_pkg::*;

    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic              wr_hit, rd_hit;
    logic [SLOT_W-1:0] wr_slot, rd_slot;
    logic [4:0]        wr_dw, rd_dw;
    logic [31:0]       rd_val;

    logic        en_a  [NUM_SLOTS];
    logic [7:0]  dus_a [NUM_SLOTS];
    logic [7:0]  cap_a [NUM_SLOTS];
    logic [31:0] ext_a [NUM_SLOTS];

    keyslot_addr_dec #(.NUM_SLOTS(NUM_SLOTS), .CFG_PTR(CFG_PTR), .ADDR_W(ADDR_W)) u_wdec (
        .addr_i(wr_addr), .hit_o(wr_hit), .slot_o(wr_slot), .dw_o(wr_dw));

    keyslot_addr_dec #(.NUM_SLOTS(NUM_SLOTS), .CFG_PTR(CFG_PTR), .ADDR_W(ADDR_W)) u_rdec (
        .addr_i(rd_addr), .hit_o(rd_hit), .slot_o(rd_slot), .dw_o(rd_dw));

    // One entry per slot, each with its own decoded write strobe.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic we_s;
        assign we_s = wr_en && wr_hit && (wr_slot == SLOT_W'(s));

        keyslot_entry u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (we_s),
            .dw_i    (wr_dw),
            .wdata_i (wr_data),
            .en_o    (en_a[s]),
            .dus_o   (dus_a[s]),
            .cap_o   (cap_a[s]),
            .ext_o   (ext_a[s]),
            .key_o   (slot_key[s*512 +: 512])
        );

        assign slot_en[s]           = en_a[s];
        assign slot_dus[s*8 +: 8]   = dus_a[s];
        assign slot_cap[s*8 +: 8]   = cap_a[s];
        assign slot_ext[s*32 +: 32] = ext_a[s];
    end

    // Read-back selection: only control and extra words are visible.
    always_comb begin
        rd_val = '0;
        if (rd_hit) begin
            if (rd_dw == DW_CTRL)
                rd_val = ctrl_image(en_a[rd_slot], cap_a[rd_slot], dus_a[rd_slot]);
            else if (rd_dw == DW_EXT)
                rd_val = ext_a[rd_slot];
        end
    end

    // Read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_val;
    end

    // R1: reset leaves every slot disabled
    a_r1_reset_disables: assert property (@(posedge clk)
        !rst_n |=> (slot_en == '0));

    // R6: writes outside the populated window leave all slots untouched
    a_r6_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit) |=> ($stable(slot_en) && $stable(slot_key)));

    // R7: key words never read back
    a_r7_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && rd_dw < 5'd16) |=> (rd_data == 32'd0));
endmodule

// File: tb/keyslot_cfg_bank_tb.sv
module keyslot_cfg_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS  = 4;
    localparam int PTR = 1;
    localparam int AW  = 12;
    localparam int BASE = PTR * 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [31:0]     wr_data = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic [31:0]     rd_data;
    logic [NS-1:0]   slot_en;
    logic [NS*8-1:0] slot_dus, slot_cap;
    logic [NS*32-1:0]  slot_ext;
    logic [NS*512-1:0] slot_key;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    keyslot_cfg_bank #(.NUM_SLOTS(NS), .CFG_PTR(PTR), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .slot_en(slot_en), .slot_dus(slot_dus),
        .slot_cap(slot_cap), .slot_ext(slot_ext), .slot_key(slot_key));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [AW-1:0] waddr(int s, int d);
        return AW'(BASE + s*128 + d*4);
    endfunction

    function automatic logic [31:0] kval(int s, int d);
        return 32'(32'h5A5A0000 + s*32'h01000193 + d*32'h00010003);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        v = rd_data;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 enables", 32'(slot_en), 32'd0);
        chk("R1 keys", 32'(|slot_key), 32'd0);
        rd(waddr(0, 16), v);
        chk("R1 ctrl read", v, 32'd0);

        // Sweep every slot and key word
        for (int s = 0; s < NS; s++) begin
            for (int d = 0; d < 16; d++) wr(waddr(s, d), kval(s, d));
            chk("R3 not enabled before ctrl", 32'(slot_en[s]), 32'd0);
            wr(waddr(s, 17), 32'(s*7 + 1));
            // reserved bits 30:16 set to junk
            wr(waddr(s, 16), {1'b1, 15'h7ABC, 8'(s + 2), 8'(1 << s)});
            chk("R3 enabled by ctrl", 32'(slot_en[s]), 32'd1);
            chk("R3 dus mask", 32'(slot_dus[s*8 +: 8]), 32'(1 << s));
            chk("R3 cap index", 32'(slot_cap[s*8 +: 8]), 32'(s + 2));
            chk("R5 ext word", slot_ext[s*32 +: 32], 32'(s*7 + 1));
            for (int d = 0; d < 16; d++)
                chk("R5 key word", slot_key[s*512 + d*32 +: 32], kval(s, d));
            rd(waddr(s, 16), v);
            chk("R7 ctrl readback", v, {1'b1, 15'b0, 8'(s + 2), 8'(1 << s)});
            rd(waddr(s, 17), v);
            chk("R7 ext readback", v, 32'(s*7 + 1));
            rd(waddr(s, 3), v);
            chk("R7 key reads zero", v, 32'd0);
            wr(waddr(s, 20), 32'hFFFF_FFFF);
            rd(waddr(s, 20), v);
            chk("R7 reserved reads zero", v, 32'd0);
        end
        chk("R8 all slots still enabled", 32'(slot_en), 32'hF);
        chk("R8 slot0 key kept", slot_key[0 +: 32], kval(0, 0));
        chk("R2 slot3 word15 placement", slot_key[3*512 + 15*32 +: 32], kval(3, 15));

        // R4: key write to armed slot 1 clears only its enable
        wr(waddr(1, 5), 32'hDEAD_BEEF);
        chk("R4 enable cleared", 32'(slot_en), 32'b1101);
        chk("R4 key stored", slot_key[512 + 5*32 +: 32], 32'hDEAD_BEEF);

        // R3: ctrl write with enable clear disables and loads fields
        wr(waddr(2, 16), 32'h0000_3355);
        chk("R3 ctrl clear disables", 32'(slot_en), 32'b1001);
        chk("R3 fields loaded", 32'(slot_dus[16 +: 8]), 32'h55);

        // R6: outside the window
        wr(waddr(4, 0), 32'h1234_5678);
        wr(waddr(4, 16), 32'h8000_0101);
        wr(AW'(BASE - 16), 32'hFFFF_FFFF);
        chk("R6 enables unchanged", 32'(slot_en), 32'b1001);
        chk("R6 slot0 key unchanged", slot_key[0 +: 32], kval(0, 0));
        chk("R6 slot3 key unchanged", slot_key[3*512 +: 32], kval(3, 0));
        rd(waddr(4, 16), v);
        chk("R6 read beyond slots", v, 32'd0);
        rd(waddr(4, 17), v);
        chk("R6 read beyond slots ext", v, 32'd0);

        // Eviction of slot 3: zero every word
        for (int d = 0; d < 32; d++) wr(waddr(3, d), 32'd0);
        chk("R3 evicted disabled", 32'(slot_en), 32'b0001);
        chk("R5 evicted key zero", 32'(|slot_key[3*512 +: 512]), 32'd0);
        chk("R8 slot0 survives evict", slot_key[15*32 +: 32], kval(0, 15));

        // R2: low address bits ignored
        wr(waddr(3, 16) + AW'(2), 32'h8000_0F01);
        chk("R2 low bits ignored", 32'(slot_en), 32'b1001);
        rd(waddr(3, 16) + AW'(3), v);
        chk("R2 low bits on read", v, 32'h8000_0F01);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule